// File: doc/BRIEF.md
# Adaptive Half-Bridge Switching-Frequency Regulator

This block drives a half-bridge. It produces complementary high-side and low-side gate commands from a switching period held as a count of clock cycles, and it inserts a programmable dead time before each turn-on. Two comparator inputs report whether the switch node has already reached the rail that the next switch is about to connect. The block samples each comparator at the turn-on instant of the matching switch. From the two samples it decides, once per period, whether to shorten or lengthen the period.

If both transitions of a period completed within the dead time, the ripple current was larger than needed. The block then raises the frequency by subtracting a step from the period. If either transition was still incomplete at turn-on, the block lowers the frequency by adding the step. The period is bounded at both ends. The loop therefore settles where one edge is just lossless. At heavy load it rests at the lowest frequency and runs in hard switching.

All pins are plain control and status signals. No data stream crosses the block's edge, so no valid/ready handshake or back-pressure applies.

Top module: `swfreq_regulator`

## Requirements
- R1: `gate_hs` and `gate_ls` are never high in the same cycle, and both change only on the clock edge (they are registered).
- R2: Each period is laid out as follows: `dead_time` cycles with both gates low, then the low-side on-time, then `dead_time` cycles with both gates low, then the high-side on-time up to the period end. `dead_time` and `duty` are captured at each period boundary, so changes in the middle of a period have no effect until the next one.
- R3: `det_ls` and `det_hs` pass through a two-flop synchroniser. A synchronised value is captured on the clock edge where the matching gate output rises (low side, then high side).
- R4: When both captured values of a period are 1 (transition complete), `up_pulse` is high for exactly one cycle, on the same edge on which `gate_hs` rises.
- R5: When either captured value of a period is 0, `dn_pulse` is high for exactly one cycle instead, on that same edge. The two pulses are never high together.
- R6: Detect values present at any other edge of the period have no influence on the pulses or on the period.
- R7: At each period boundary the period becomes the current period minus `step` (increase) or plus `step` (decrease), clamped to [PERIOD_MIN, PERIOD_MAX]. It stays unchanged within a period.
- R8: After synchronous reset the period is PERIOD_MIN, both gates and both pulses are low, and the low-side gate first rises after `dead_time` cycles.
- R9: The high-side on-time equals `duty`, clamped to the range 1 to period − 2·`dead_time` − 1. The low side takes the rest, so it is always on for at least one cycle.
- R10: The `period` output shows the period in force for the current switching cycle. It updates on the edge on which the new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dead_time | input | DW | Dead time in clock cycles |
| duty | input | W | Requested high-side on-time in clock cycles |
| step | input | W | Period adjustment per decision |
| det_hs | input | 1 | Switch node at high rail (asynchronous) |
| det_ls | input | 1 | Switch node at low rail (asynchronous) |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| up_pulse | output | 1 | One-cycle frequency-increase decision |
| dn_pulse | output | 1 | One-cycle frequency-decrease decision |
| period | output | W | Current switching period in clock cycles |

## Verification
The bench builds the block with W=16, DW=4, PERIOD_MIN=40 and PERIOD_MAX=120. Periods stay short, so both clamp ends are reached within a few dozen switching cycles from either start. With a 4-bit dead time of up to 15 cycles, the on-time clamp is reached from both sides, including the largest dead time against the shortest period. Random comparator activity, together with mid-period changes of `dead_time` and `duty`, exercises the sampling instants and the boundary capture against the bench's own model.

// File: rtl/swr_pkg.sv
package swr_pkg;

  typedef enum logic [1:0] {
    PH_GAP_A = 2'd0,
    PH_LOW   = 2'd1,
    PH_GAP_B = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  typedef struct packed {
    logic up;
    logic dn;
  } verdict_t;

endpackage

// File: rtl/swr_period_reg.sv
module swr_period_reg #(
  parameter int W     = 16,
  parameter int P_MIN = 40,
  parameter int P_MAX = 400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         raise,
  input  logic [W-1:0] step,
  output logic [W-1:0] p_q,
  output logic [W-1:0] p_adj
);

  localparam logic [W:0] LIM_LO = (W+1)'(P_MIN);
  localparam logic [W:0] LIM_HI = (W+1)'(P_MAX);

  logic [W:0] shorter;
  logic [W:0] longer;

  always_comb begin
    shorter = {1'b0, p_q} - {1'b0, step};
    longer  = {1'b0, p_q} + {1'b0, step};
    if (raise) begin
      if (shorter[W] || (shorter < LIM_LO)) p_adj = LIM_LO[W-1:0];
      else                                  p_adj = shorter[W-1:0];
    end else begin
      if (longer > LIM_HI) p_adj = LIM_HI[W-1:0];
      else                 p_adj = longer[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    p_q <= LIM_LO[W-1:0];
    else if (wrap) p_q <= p_adj;
  end

  AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q >= LIM_LO[W-1:0]) && (p_q <= LIM_HI[W-1:0])); // R7

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(p_q)); // R7

endmodule

// File: rtl/swr_phase_gen.sv
module swr_phase_gen
  import swr_pkg::*;
#(
  parameter int W     = 16,
  parameter int DW    = 4,
  parameter int P_MIN = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dead_time,
  input  logic [W-1:0]  duty,
  input  logic [W-1:0]  period_now,
  input  logic [W-1:0]  period_adj,
  output logic          wrap,
  output logic          ls_on_evt,
  output logic          hs_on_evt,
  output phase_e        phase
);

  localparam logic [W-1:0] P_RESET = W'(P_MIN);

  logic [W-1:0]  cnt;
  logic [DW-1:0] dt_q;
  logic [W-1:0]  hs_q;
  logic [W-1:0]  dt_w;
  logic [W-1:0]  ls_end;
  logic [W-1:0]  hs_start;

  function automatic logic [W-1:0] fit_on(input logic [W-1:0] req,
                                          input logic [W-1:0] per,
                                          input logic [DW-1:0] gap);
    logic [W-1:0] lim;
    lim = per - W'({gap, 1'b0}) - W'(1);
    if (req == '0)      return W'(1);
    else if (req > lim) return lim;
    else                return req;
  endfunction

  always_comb begin
    dt_w     = W'(dt_q);
    hs_start = period_now - hs_q;
    ls_end   = hs_start - dt_w;
    wrap      = (cnt == period_now - W'(1));
    ls_on_evt = (cnt == dt_w);
    hs_on_evt = (cnt == hs_start);
    if (cnt < dt_w)          phase = PH_GAP_A;
    else if (cnt < ls_end)   phase = PH_LOW;
    else if (cnt < hs_start) phase = PH_GAP_B;
    else                     phase = PH_HIGH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      dt_q <= dead_time;
      hs_q <= fit_on(duty, P_RESET, dead_time);
    end else if (wrap) begin
      cnt  <= '0;
      dt_q <= dead_time;
      hs_q <= fit_on(duty, period_adj, dead_time);
    end else begin
      cnt  <= cnt + W'(1);
    end
  end

  AST_COUNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period_now); // R2

  AST_LOW_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on_evt |-> !ls_on_evt); // R3

endmodule

// File: rtl/swr_edge_judge.sv
module swr_edge_judge
  import swr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     det_hs,
  input  logic     det_ls,
  input  logic     ls_on_evt,
  input  logic     hs_on_evt,
  output verdict_t verdict,
  output logic     raise
);

  logic hs_m, hs_s, ls_m, ls_s;
  logic ls_ok, hs_ok;
  logic ls_ok_now, hs_ok_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_m <= 1'b0;
      hs_s <= 1'b0;
      ls_m <= 1'b0;
      ls_s <= 1'b0;
    end else begin
      hs_m <= det_hs;
      hs_s <= hs_m;
      ls_m <= det_ls;
      ls_s <= ls_m;
    end
  end

  always_comb begin
    ls_ok_now = ls_on_evt ? ls_s : ls_ok;
    hs_ok_now = hs_on_evt ? hs_s : hs_ok;
    raise     = ls_ok_now & hs_ok_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_ok   <= 1'b0;
      hs_ok   <= 1'b0;
      verdict <= '0;
    end else begin
      ls_ok <= ls_ok_now;
      hs_ok <= hs_ok_now;
      if (hs_on_evt) begin
        verdict.up <= raise;
        verdict.dn <= ~raise;
      end else begin
        verdict <= '0;
      end
    end
  end

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(verdict.up && verdict.dn)); // R5

  AST_UP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.up |=> !verdict.up); // R4

  AST_DN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.dn |=> !verdict.dn); // R5

endmodule

// File: rtl/swfreq_regulator.sv
module swfreq_regulator
  import swr_pkg::*;
#(
  parameter int W          = 16,
  parameter int DW         = 4,
  parameter int PERIOD_MIN = 40,
  parameter int PERIOD_MAX = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dead_time,
  input  logic [W-1:0]  duty,
  input  logic [W-1:0]  step,
  input  logic          det_hs,
  input  logic          det_ls,
  output logic          gate_hs,
  output logic          gate_ls,
  output logic          up_pulse,
  output logic          dn_pulse,
  output logic [W-1:0]  period
);

  logic         wrap;
  logic         ls_on_evt;
  logic         hs_on_evt;
  logic         raise;
  logic [W-1:0] p_q;
  logic [W-1:0] p_adj;
  phase_e       phase;
  verdict_t     verdict;

  swr_period_reg #(
    .W     (W),
    .P_MIN (PERIOD_MIN),
    .P_MAX (PERIOD_MAX)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (wrap),
    .raise (raise),
    .step  (step),
    .p_q   (p_q),
    .p_adj (p_adj)
  );

  swr_phase_gen #(
    .W     (W),
    .DW    (DW),
    .P_MIN (PERIOD_MIN)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .dead_time  (dead_time),
    .duty       (duty),
    .period_now (p_q),
    .period_adj (p_adj),
    .wrap       (wrap),
    .ls_on_evt  (ls_on_evt),
    .hs_on_evt  (hs_on_evt),
    .phase      (phase)
  );

  swr_edge_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .det_hs    (det_hs),
    .det_ls    (det_ls),
    .ls_on_evt (ls_on_evt),
    .hs_on_evt (hs_on_evt),
    .verdict   (verdict),
    .raise     (raise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_hs <= 1'b0;
      gate_ls <= 1'b0;
    end else begin
      gate_hs <= (phase == PH_HIGH);
      gate_ls <= (phase == PH_LOW);
    end
  end

  assign up_pulse = verdict.up;
  assign dn_pulse = verdict.dn;
  assign period   = p_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls)); // R1

  AST_DECISION_AT_HS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs) |-> (up_pulse || dn_pulse)); // R4

  AST_PULSE_DURING_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse || dn_pulse) |-> gate_hs); // R5

endmodule

// File: tb/test_swfreq_regulator.sv
module test_swfreq_regulator;

  localparam int W    = 16;
  localparam int DW   = 4;
  localparam int PMIN = 40;
  localparam int PMAX = 120;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] dead_time = 4'd3;
  logic [W-1:0]  duty = 16'd10;
  logic [W-1:0]  step = 16'd8;
  logic          det_hs = 1'b0;
  logic          det_ls = 1'b0;
  logic          gate_hs, gate_ls, up_pulse, dn_pulse;
  logic [W-1:0]  period;

  always #10 clk = ~clk;

  swfreq_regulator #(.W(W), .DW(DW), .PERIOD_MIN(PMIN), .PERIOD_MAX(PMAX)) i_swfreq_regulator (
    .clk(clk), .rst_n(rst_n), .dead_time(dead_time), .duty(duty), .step(step),
    .det_hs(det_hs), .det_ls(det_ls), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .period(period));

  int checks = 0;
  int fails  = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  int m_cnt, m_p, m_dt, m_hs;
  bit m_lok, m_hok;
  bit m_l1, m_l2, m_h1, m_h2;
  bit e_gh, e_gl, e_up, e_dn;

  function automatic int on_time(int req, int per, int gap);
    int top = per - 2 * gap - 1;
    if (req < 1) return 1;
    if (req > top) return top;
    return req;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_p = PMIN; m_dt = dead_time;
      m_hs = on_time(duty, PMIN, dead_time);
      m_lok = 0; m_hok = 0; m_l1 = 0; m_l2 = 0; m_h1 = 0; m_h2 = 0;
      e_gh = 0; e_gl = 0; e_up = 0; e_dn = 0;
    end else begin
      bit seen_l, seen_h;
      seen_l = m_l2; seen_h = m_h2;
      m_l2 = m_l1; m_l1 = det_ls;
      m_h2 = m_h1; m_h1 = det_hs;
      e_gl = (m_cnt >= m_dt) && (m_cnt < m_p - m_dt - m_hs);
      e_gh = (m_cnt >= m_p - m_hs);
      e_up = 0; e_dn = 0;
      if (m_cnt == m_dt) m_lok = seen_l;
      if (m_cnt == m_p - m_hs) begin
        m_hok = seen_h;
        e_up = m_lok && m_hok;
        e_dn = !e_up;
      end
      if (m_cnt == m_p - 1) begin
        int np;
        if (m_lok && m_hok) np = (m_p - step < PMIN) ? PMIN : m_p - step;
        else                np = (m_p + step > PMAX) ? PMAX : m_p + step;
        m_p = np; m_dt = dead_time; m_hs = on_time(duty, np, dead_time);
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      check("R1 R2 R9 gate_hs", gate_hs, e_gh);
      check("R1 R2 R8 R9 gate_ls", gate_ls, e_gl);
      check("R3 R4 R6 up_pulse", up_pulse, e_up);
      check("R3 R5 R6 dn_pulse", dn_pulse, e_dn);
      check("R7 R10 period", period, m_p);
    end
  end

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (mode)
        0: begin det_hs = 1; det_ls = 1; end
        1: begin det_hs = 1; det_ls = 0; end
        default: begin det_hs = $urandom_range(0, 1); det_ls = $urandom_range(0, 1); end
      endcase
      if (mode == 3 && ($urandom_range(0, 15) == 0)) begin
        dead_time = $urandom_range(0, 15);
        duty = $urandom_range(0, 130);
      end
    end
  endtask

  task automatic reset_and_check();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check("R8 reset gate_hs", gate_hs, 0);
    check("R8 reset gate_ls", gate_ls, 0);
    check("R8 reset up_pulse", up_pulse, 0);
    check("R8 reset dn_pulse", dn_pulse, 0);
    check("R8 reset period", period, PMIN);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    reset_and_check();
    compare_on = 1;
    // R7 low clamp: every transition complete
    run(2000, 0);
    @(negedge clk); check("R7 R4 saturate at minimum", period, PMIN);
    // R7 high clamp: low-side edge always incomplete
    run(2000, 1);
    @(negedge clk); check("R7 R5 saturate at maximum", period, PMAX);
    // random comparator activity, fixed setup
    run(4000, 2);
    // R2 R9 extreme on-times and dead times
    dead_time = 15; duty = 0; run(1500, 2);
    duty = 16'hFFFF; run(1500, 2);
    dead_time = 0; duty = 16'hFFFF; run(1500, 2);
    // R2 R6 mid-period changes with random detects
    run(6000, 3);
    compare_on = 0;
    dead_time = 5; duty = 20;
    reset_and_check();
    compare_on = 1;
    run(3000, 3);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule